// File: doc/BRIEF.md
# Job Ring Slot Accounting Controller

This block does the slot bookkeeping for one job ring. The ring has two halves. The input ring holds descriptor slots: software fills them and hardware takes them. The output ring holds status slots: hardware fills them and software empties them. Software and hardware do not share pointers. They pass credits through count registers instead. Software writes how many jobs it has added and how many results it has removed. Hardware signals each descriptor it takes with a consume strobe and each result it writes with a produce strobe. Fetching descriptors, running jobs and writing results to memory all happen outside the block.

The block keeps the room left in the input ring, the number of full output slots, the read index of the input ring and the write index of the output ring. It raises a completion interrupt, which can be coalesced by a completion count or by a timer. It flags a ring error when software claims more credits than exist. It also provides a ring reset command that takes a fixed number of cycles and reports its halt progress.

Top module: `jr_ring_ctrl`

## Requirements
- R1: A write to a size register keeps only bits 9:0 of the written value. The same write re-initialises that half of the ring: input room becomes the new size, output full becomes 0, and the index becomes 0.
- R2: A write of n to the add register lowers input room by n. A consume strobe returns one slot (room plus 1), but only when room is below the input size. Otherwise the strobe is ignored.
- R3: A write of n to the drain register lowers output full by n. A produce strobe adds one full slot, but only when full is below the output size. Otherwise the strobe is ignored.
- R4: Each accepted consume advances the read index by one, and each accepted produce advances the write index by one. Each index wraps to 0 when it reaches the size of its ring.
- R5: A write to add that exceeds room, or a write to drain that exceeds full, leaves the count unchanged. It sets status bit 1 and loads status bits 11:8 with the error code: 9 for the add overflow and 8 for the drain overflow.
- R6: Writing 1 clears status bit 0, status bit 1 or the halt-complete state. A completion or error in the same cycle wins over the clear.
- R7: The irq output is high when status bit 0 or status bit 1 is set and config bit 0 (mask) is clear.
- R8: When config bit 1 (coalesce) is clear, every accepted produce sets status bit 0 on the same clock edge.
- R9: When coalescing is on, status bit 0 sets when the number of accepted produces since the last clear reaches config bits 15:8. A threshold of 0 counts as 1.
- R10: When coalescing is on and config bits 31:16 hold a nonzero value T, status bit 0 sets T cycles after the edge that counted the first pending completion.
- R11: When status bit 1 and config bit 2 (stop on error) are both set, consume and produce strobes are ignored.
- R12: Writing 1 to bit 0 of the command register starts a ring reset. For 2 cycles, status bits 3:2 read 1 (value 0x4) and both strobes are ignored. The counts and indices then return to their empty-ring values, status bits 1:0 clear, and bits 3:2 read 2 (value 0x8).
- R13: The register word addresses are: 0 input size, 1 input room, 2 add, 3 output size, 4 output full, 5 drain, 6 status, 7 config, 8 command, 9 read index, 10 write index. Reads are combinational. Write-only and unknown addresses read as 0. After reset every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| hw_consume | input | 1 | Hardware took one input descriptor |
| hw_produce | input | 1 | Hardware wrote one output result |
| irq | output | 1 | Completion or error interrupt |

## Verification
A wrong credit count appears on the very next register read. Room or full would be off by the error. The error then grows. A strobe that should be refused would be accepted, or one that should be accepted would be refused, and an overflow error would be raised at the wrong moment. An index error appears first at the wrap, as a read or write index that does not return to 0. A coalescing fault appears as irq rising a cycle early or late relative to the timer threshold, or one completion early or late relative to the count threshold. The bench therefore samples irq cycle by cycle around both thresholds.

// File: rtl/jr_ring_pkg.sv
package jr_ring_pkg;
  parameter int unsigned REG_DW    = 32;
  parameter int unsigned REG_AW    = 4;
  parameter int unsigned RING_SZW  = 10;

  localparam logic [REG_AW-1:0] A_IN_SIZE  = 4'd0;
  localparam logic [REG_AW-1:0] A_IN_ROOM  = 4'd1;
  localparam logic [REG_AW-1:0] A_IN_ADD   = 4'd2;
  localparam logic [REG_AW-1:0] A_OUT_SIZE = 4'd3;
  localparam logic [REG_AW-1:0] A_OUT_FULL = 4'd4;
  localparam logic [REG_AW-1:0] A_OUT_DRN  = 4'd5;
  localparam logic [REG_AW-1:0] A_STATUS   = 4'd6;
  localparam logic [REG_AW-1:0] A_CONFIG   = 4'd7;
  localparam logic [REG_AW-1:0] A_COMMAND  = 4'd8;
  localparam logic [REG_AW-1:0] A_RD_IDX   = 4'd9;
  localparam logic [REG_AW-1:0] A_WR_IDX   = 4'd10;

  localparam logic [3:0] ERR_DRAIN_OVF = 4'd8;
  localparam logic [3:0] ERR_FILL_OVF  = 4'd9;

  typedef enum logic [1:0] {
    HALT_NONE = 2'd0,
    HALT_BUSY = 2'd1,
    HALT_DONE = 2'd2
  } halt_e;

  // next ring position, wrapping at the programmed size
  function automatic logic [RING_SZW-1:0] wrap_inc(input logic [RING_SZW-1:0] idx,
                                                   input logic [RING_SZW-1:0] size);
    logic [RING_SZW:0] nx;
    nx = {1'b0, idx} + 1'b1;
    return (nx >= {1'b0, size}) ? '0 : nx[RING_SZW-1:0];
  endfunction

  // a software credit claim fits within what is available
  function automatic logic credit_fits(input logic [REG_DW-1:0] n,
                                       input logic [RING_SZW-1:0] avail);
    return n <= REG_DW'(avail);
  endfunction
endpackage

// File: rtl/jr_slot_tracker.sv
module jr_slot_tracker
  import jr_ring_pkg::*;
#(
  parameter int unsigned SZW       = RING_SZW,
  parameter int unsigned DW        = REG_DW,
  parameter bit          INIT_FULL = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           size_we,
  input  logic [DW-1:0]  size_wdata,
  input  logic           ring_clear,
  input  logic           step_req,
  input  logic           take_req,
  input  logic [DW-1:0]  take_n,
  output logic [SZW-1:0] size_q,
  output logic [SZW-1:0] cnt_q,
  output logic [SZW-1:0] idx_q,
  output logic           step_ok,
  output logic           take_ovf
);
  logic [SZW-1:0] new_size;
  logic           hold;
  logic           take_ok;
  logic [SZW-1:0] take_amt;

  assign new_size = size_wdata[SZW-1:0];
  assign hold     = ring_clear || size_we;
  assign step_ok  = step_req && !hold && (cnt_q < size_q);
  assign take_ovf = take_req && !hold && !credit_fits(take_n, cnt_q);
  assign take_ok  = take_req && !hold && !take_ovf;
  assign take_amt = take_ok ? take_n[SZW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (size_we) begin
      size_q <= new_size;
      cnt_q  <= INIT_FULL ? new_size : '0;
      idx_q  <= '0;
    end else if (ring_clear) begin
      cnt_q  <= INIT_FULL ? size_q : '0;
      idx_q  <= '0;
    end else begin
      cnt_q <= cnt_q + SZW'(step_ok) - take_amt;
      if (step_ok) idx_q <= wrap_inc(idx_q, size_q);
    end
  end
endmodule

// File: rtl/jr_irq_coalesce.sv
module jr_irq_coalesce #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             ack,
  input  logic             evt,
  input  logic             coal_en,
  input  logic [CNT_W-1:0] cnt_thr,
  input  logic [TMR_W-1:0] tmr_thr,
  output logic             done_q,
  output logic             count_hit,
  output logic             timer_hit
);
  logic [CNT_W-1:0] cnt_q, cnt_base, cnt_nx, eff_thr;
  logic [TMR_W-1:0] tmr_q;

  assign eff_thr  = (cnt_thr == '0) ? CNT_W'(1) : cnt_thr;
  assign cnt_base = ack ? '0 : cnt_q;
  assign cnt_nx   = (evt && cnt_base != '1) ? cnt_base + 1'b1 : cnt_base;
  assign count_hit = evt && (!coal_en || cnt_nx >= eff_thr);
  assign timer_hit = coal_en && (tmr_thr != '0) && (cnt_q != '0) && !done_q && !ack &&
                     (({1'b0, tmr_q} + 1'b1) >= {1'b0, tmr_thr});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tmr_q  <= '0;
      done_q <= 1'b0;
    end else if (clear) begin
      cnt_q  <= '0;
      tmr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      if (count_hit || timer_hit) done_q <= 1'b1;
      else if (ack)               done_q <= 1'b0;
      if (ack || cnt_q == '0 || done_q) tmr_q <= '0;
      else if (tmr_q != '1)             tmr_q <= tmr_q + 1'b1;
    end
  end
endmodule

// File: rtl/jr_ring_ctrl.sv
module jr_ring_ctrl
  import jr_ring_pkg::*;
#(
  parameter int unsigned SZW        = RING_SZW,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned TMR_W      = 16,
  parameter int unsigned RST_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              hw_consume,
  input  logic              hw_produce,
  output logic              irq
);
  localparam int unsigned NRING = 2;
  localparam int unsigned RCW   = $clog2(RST_CYCLES + 1);
  localparam int unsigned CT_LO = 8;
  localparam int unsigned TT_LO = 16;

  // configuration
  logic             cfg_mask, cfg_coal, cfg_soe;
  logic [CNT_W-1:0] cfg_cnt_thr;
  logic [TMR_W-1:0] cfg_tmr_thr;
  // status
  logic             err_q;
  logic [3:0]       err_type_q;
  halt_e            halt_q;
  logic [RCW-1:0]   rst_cnt_q;
  logic             done_q;

  // named internal events
  logic rst_busy, stall, cmd_go;
  logic consume_go, produce_go, consume_ok, produce_ok;
  logic fill_ovf, drain_ovf;
  logic ack_done, ack_err, ack_halt;
  logic count_hit, timer_hit;

  function automatic logic sel(input logic [REG_AW-1:0] a);
    return reg_we && (reg_addr == a);
  endfunction

  assign rst_busy   = (rst_cnt_q != '0);
  assign stall      = err_q && cfg_soe;
  assign cmd_go     = sel(A_COMMAND) && reg_wdata[0] && !rst_busy;
  assign consume_go = hw_consume && !stall && !rst_busy;
  assign produce_go = hw_produce && !stall && !rst_busy;
  assign ack_done   = sel(A_STATUS) && reg_wdata[0];
  assign ack_err    = sel(A_STATUS) && reg_wdata[1];
  assign ack_halt   = sel(A_STATUS) && reg_wdata[3];

  // two ring halves: index 0 input (starts full of room), 1 output
  logic [NRING-1:0] size_we, step_req, take_req, step_ok, take_ovf;
  logic [SZW-1:0]   ring_size [NRING];
  logic [SZW-1:0]   ring_cnt  [NRING];
  logic [SZW-1:0]   ring_idx  [NRING];

  assign size_we[0]  = sel(A_IN_SIZE);
  assign size_we[1]  = sel(A_OUT_SIZE);
  assign step_req[0] = consume_go;
  assign step_req[1] = produce_go;
  assign take_req[0] = sel(A_IN_ADD) && !rst_busy;
  assign take_req[1] = sel(A_OUT_DRN) && !rst_busy;

  for (genvar g = 0; g < NRING; g++) begin : g_ring
    jr_slot_tracker #(
      .SZW      (SZW),
      .DW       (REG_DW),
      .INIT_FULL(g == 0)
    ) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .size_we   (size_we[g]),
      .size_wdata(reg_wdata),
      .ring_clear(rst_busy),
      .step_req  (step_req[g]),
      .take_req  (take_req[g]),
      .take_n    (reg_wdata),
      .size_q    (ring_size[g]),
      .cnt_q     (ring_cnt[g]),
      .idx_q     (ring_idx[g]),
      .step_ok   (step_ok[g]),
      .take_ovf  (take_ovf[g])
    );
  end

  logic [SZW-1:0] in_size, in_room, rd_idx, out_size, out_full, wr_idx;
  assign in_size    = ring_size[0];
  assign in_room    = ring_cnt[0];
  assign rd_idx     = ring_idx[0];
  assign out_size   = ring_size[1];
  assign out_full   = ring_cnt[1];
  assign wr_idx     = ring_idx[1];
  assign consume_ok = step_ok[0];
  assign produce_ok = step_ok[1];
  assign fill_ovf   = take_ovf[0];
  assign drain_ovf  = take_ovf[1];

  jr_irq_coalesce #(
    .CNT_W(CNT_W),
    .TMR_W(TMR_W)
  ) u_coal (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (rst_busy),
    .ack      (ack_done),
    .evt      (produce_ok),
    .coal_en  (cfg_coal),
    .cnt_thr  (cfg_cnt_thr),
    .tmr_thr  (cfg_tmr_thr),
    .done_q   (done_q),
    .count_hit(count_hit),
    .timer_hit(timer_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_mask    <= 1'b0;
      cfg_coal    <= 1'b0;
      cfg_soe     <= 1'b0;
      cfg_cnt_thr <= '0;
      cfg_tmr_thr <= '0;
    end else if (sel(A_CONFIG)) begin
      cfg_mask    <= reg_wdata[0];
      cfg_coal    <= reg_wdata[1];
      cfg_soe     <= reg_wdata[2];
      cfg_cnt_thr <= reg_wdata[CT_LO +: CNT_W];
      cfg_tmr_thr <= reg_wdata[TT_LO +: TMR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q      <= 1'b0;
      err_type_q <= '0;
    end else if (rst_busy) begin
      err_q      <= 1'b0;
      err_type_q <= '0;
    end else if (fill_ovf) begin
      err_q      <= 1'b1;
      err_type_q <= ERR_FILL_OVF;
    end else if (drain_ovf) begin
      err_q      <= 1'b1;
      err_type_q <= ERR_DRAIN_OVF;
    end else if (ack_err) begin
      err_q      <= 1'b0;
      err_type_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_cnt_q <= '0;
      halt_q    <= HALT_NONE;
    end else begin
      if (cmd_go)        rst_cnt_q <= RCW'(RST_CYCLES);
      else if (rst_busy) rst_cnt_q <= rst_cnt_q - 1'b1;
      if (cmd_go)                                  halt_q <= HALT_BUSY;
      else if (rst_cnt_q == RCW'(1))               halt_q <= HALT_DONE;
      else if (ack_halt && halt_q == HALT_DONE)    halt_q <= HALT_NONE;
    end
  end

  logic [REG_DW-1:0] status_w, config_w;
  assign status_w = {{(REG_DW-12){1'b0}}, err_type_q, 4'b0000, halt_q, err_q, done_q};
  assign config_w = REG_DW'({cfg_tmr_thr, cfg_cnt_thr, 5'b00000, cfg_soe, cfg_coal, cfg_mask});

  always_comb begin
    case (reg_addr)
      A_IN_SIZE:  reg_rdata = REG_DW'(in_size);
      A_IN_ROOM:  reg_rdata = REG_DW'(in_room);
      A_OUT_SIZE: reg_rdata = REG_DW'(out_size);
      A_OUT_FULL: reg_rdata = REG_DW'(out_full);
      A_STATUS:   reg_rdata = status_w;
      A_CONFIG:   reg_rdata = config_w;
      A_RD_IDX:   reg_rdata = REG_DW'(rd_idx);
      A_WR_IDX:   reg_rdata = REG_DW'(wr_idx);
      default:    reg_rdata = '0;
    endcase
  end

  assign irq = (done_q || err_q) && !cfg_mask;
endmodule

// File: rtl/jr_ring_ctrl_chk.sv
module jr_ring_ctrl_chk
  import jr_ring_pkg::*;
#(
  parameter int unsigned SZW = RING_SZW
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_we,
  input logic [SZW-1:0] in_size,
  input logic [SZW-1:0] in_room,
  input logic [SZW-1:0] rd_idx,
  input logic [SZW-1:0] out_size,
  input logic [SZW-1:0] out_full,
  input logic [SZW-1:0] wr_idx,
  input logic           fill_ovf,
  input logic           drain_ovf,
  input logic           produce_ok,
  input logic           cfg_coal,
  input logic           cfg_mask,
  input logic           stall,
  input logic           rst_busy,
  input logic           done_q,
  input logic           err_q,
  input logic [3:0]     err_type_q,
  input logic [1:0]     halt_q,
  input logic           irq
);
  assert_room_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_room <= in_size);

  assert_full_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_full <= out_size);

  assert_idx_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_size == '0 ? rd_idx == '0 : rd_idx < in_size) &&
    (out_size == '0 ? wr_idx == '0 : wr_idx < out_size));

  assert_fill_ovf_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ovf |=> err_q && err_type_q == ERR_FILL_OVF);

  assert_drain_ovf_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drain_ovf |=> err_q && err_type_q == ERR_DRAIN_OVF);

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mask |-> !irq);

  assert_plain_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (produce_ok && !cfg_coal) |=> done_q);

  assert_stall_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !reg_we && !rst_busy) |=> $stable(rd_idx) && $stable(wr_idx));

  assert_halt_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q != 2'd3);
endmodule

bind jr_ring_ctrl jr_ring_ctrl_chk #(.SZW(SZW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .in_size   (in_size),
  .in_room   (in_room),
  .rd_idx    (rd_idx),
  .out_size  (out_size),
  .out_full  (out_full),
  .wr_idx    (wr_idx),
  .fill_ovf  (fill_ovf),
  .drain_ovf (drain_ovf),
  .produce_ok(produce_ok),
  .cfg_coal  (cfg_coal),
  .cfg_mask  (cfg_mask),
  .stall     (stall),
  .rst_busy  (rst_busy),
  .done_q    (done_q),
  .err_q     (err_q),
  .err_type_q(err_type_q),
  .halt_q    (halt_q),
  .irq       (irq)
);

// File: tb/jr_ring_ctrl_tb_top.sv
`timescale 1ns/100ps
module jr_ring_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [3:0]  mon_addr = '0;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        hw_consume = 1'b0;
  logic        hw_produce = 1'b0;
  logic        irq;

  int tests = 0;
  int fails = 0;
  int pending = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign reg_addr = reg_we ? wr_addr : mon_addr;

  jr_ring_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hw_consume(hw_consume), .hw_produce(hw_produce), .irq(irq)
  );

  // register map used by the bench (R13)
  localparam logic [3:0] IN_SIZE = 0, IN_ROOM = 1, IN_ADD = 2, OUT_SIZE = 3,
                         OUT_FULL = 4, OUT_DRN = 5, STATUS = 6, CONFIG = 7,
                         COMMAND = 8, RD_IDX = 9, WR_IDX = 10;

  typedef struct {
    logic [3:0]  a;
    logic [31:0] e;
    string       tag;
  } exp_t;
  exp_t sb[$];
  event sb_ev;

  // monitor: pops expected items and compares against the read port
  initial begin
    forever begin
      @(sb_ev);
      while (sb.size() > 0) begin
        mon_addr = sb[0].a;
        #0.1;
        tests++;
        if (reg_rdata !== sb[0].e) begin
          fails++;
          $display("FAIL %s: addr %0d actual 0x%0h expected 0x%0h",
                   sb[0].tag, sb[0].a, reg_rdata, sb[0].e);
        end
        void'(sb.pop_front());
        pending--;
      end
    end
  end

  task automatic expect_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.a = a; it.e = e; it.tag = tag;
    sb.push_back(it);
    pending++;
    -> sb_ev;
    wait (pending == 0);
  endtask

  task automatic expect_irq(input logic e, input string tag);
    tests++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq actual %0b expected %0b", tag, irq, e);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; wr_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic consume(input int n);
    @(negedge clk);
    hw_consume = 1'b1;
    repeat (n) @(negedge clk);
    hw_consume = 1'b0;
  endtask

  task automatic produce(input int n);
    @(negedge clk);
    hw_produce = 1'b1;
    repeat (n) @(negedge clk);
    hw_produce = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13: reset values
    expect_reg(STATUS, 32'h0, "R13 status after reset");
    expect_reg(IN_ROOM, 32'h0, "R13 room after reset");
    expect_reg(OUT_FULL, 32'h0, "R13 full after reset");
    expect_irq(1'b0, "R13 irq after reset");

    // R1: size masked to 10 bits, ring re-initialised
    wr(IN_SIZE, 32'h0000_0404);
    expect_reg(IN_SIZE, 32'd4, "R1 input size masked");
    expect_reg(IN_ROOM, 32'd4, "R1 room equals size");
    expect_reg(RD_IDX, 32'd0, "R1 read index zero");
    wr(OUT_SIZE, 32'd3);
    expect_reg(OUT_SIZE, 32'd3, "R1 output size");
    expect_reg(OUT_FULL, 32'd0, "R1 full zero");

    // R2 / R4: add and consume
    wr(IN_ADD, 32'd3);
    expect_reg(IN_ROOM, 32'd1, "R2 room after add");
    consume(2);
    expect_reg(IN_ROOM, 32'd3, "R2 room after consume");
    expect_reg(RD_IDX, 32'd2, "R4 read index advance");
    consume(2);
    expect_reg(IN_ROOM, 32'd4, "R2 consume on empty ignored");
    expect_reg(RD_IDX, 32'd3, "R2 index stops when empty");
    wr(IN_ADD, 32'd4);
    expect_reg(IN_ROOM, 32'd0, "R2 ring filled");
    consume(2);
    expect_reg(IN_ROOM, 32'd2, "R2 room after wrap consume");
    expect_reg(RD_IDX, 32'd1, "R4 read index wraps");

    // R5 / R7 / R6: add overflow
    wr(IN_ADD, 32'd5);
    expect_reg(IN_ROOM, 32'd2, "R5 room unchanged on overflow");
    expect_reg(STATUS, 32'h902, "R5 add overflow code");
    expect_irq(1'b1, "R7 irq on error");
    wr(STATUS, 32'h2);
    expect_reg(STATUS, 32'h0, "R6 error cleared");
    expect_irq(1'b0, "R7 irq low after clear");

    // R8 / R3 / R4: produce without coalescing
    produce(1);
    expect_reg(OUT_FULL, 32'd1, "R3 full after produce");
    expect_reg(WR_IDX, 32'd1, "R4 write index advance");
    expect_reg(STATUS, 32'h1, "R8 done per completion");
    expect_irq(1'b1, "R7 irq on done");
    wr(STATUS, 32'h1);
    expect_reg(STATUS, 32'h0, "R6 done cleared");
    produce(3);
    expect_reg(OUT_FULL, 32'd3, "R3 produce on full ignored");
    expect_reg(WR_IDX, 32'd0, "R4 write index wraps");
    wr(STATUS, 32'h1);
    wr(OUT_DRN, 32'd2);
    expect_reg(OUT_FULL, 32'd1, "R3 full after drain");
    wr(OUT_DRN, 32'd5);
    expect_reg(OUT_FULL, 32'd1, "R5 full unchanged on overflow");
    expect_reg(STATUS, 32'h802, "R5 drain overflow code");

    // R11: stop on error
    wr(CONFIG, 32'h4);
    produce(1);
    expect_reg(OUT_FULL, 32'd1, "R11 produce frozen");
    expect_reg(WR_IDX, 32'd0, "R11 write index frozen");
    consume(1);
    expect_reg(IN_ROOM, 32'd2, "R11 consume frozen");
    expect_reg(RD_IDX, 32'd1, "R11 read index frozen");
    wr(STATUS, 32'h2);
    produce(1);
    expect_reg(OUT_FULL, 32'd2, "R11 resumes after clear");
    expect_reg(WR_IDX, 32'd1, "R11 index resumes");
    wr(STATUS, 32'h1);

    // R7: mask
    wr(CONFIG, 32'h1);
    produce(1);
    expect_reg(STATUS, 32'h1, "R7 status set while masked");
    expect_irq(1'b0, "R7 irq masked");
    wr(STATUS, 32'h1);
    wr(OUT_DRN, 32'd3);
    expect_reg(OUT_FULL, 32'd0, "R3 drain to empty");

    // R9: count coalescing, threshold 3
    wr(CONFIG, 32'h0000_0302);
    produce(2);
    expect_reg(STATUS, 32'h0, "R9 below count threshold");
    expect_irq(1'b0, "R9 irq below threshold");
    produce(1);
    expect_reg(STATUS, 32'h1, "R9 count threshold reached");
    expect_irq(1'b1, "R9 irq at threshold");
    wr(STATUS, 32'h1);
    wr(OUT_DRN, 32'd3);

    // R10: timer coalescing, T = 5, count threshold 10
    wr(CONFIG, 32'h0005_0A02);
    produce(1);
    repeat (4) @(negedge clk);
    expect_irq(1'b0, "R10 irq one cycle before timer");
    @(negedge clk);
    expect_irq(1'b1, "R10 irq at timer threshold");
    wr(STATUS, 32'h1);
    wr(CONFIG, 32'h0);

    // R12: ring reset
    wr(IN_ADD, 32'd1);
    expect_reg(IN_ROOM, 32'd1, "R2 room before reset");
    wr(COMMAND, 32'h1);
    expect_reg(STATUS, 32'h4, "R12 halt in progress");
    produce(1);
    expect_reg(STATUS, 32'h8, "R12 halt complete");
    expect_reg(IN_ROOM, 32'd4, "R12 room restored");
    expect_reg(RD_IDX, 32'd0, "R12 read index cleared");
    expect_reg(OUT_FULL, 32'd0, "R12 produce ignored, full empty");
    expect_reg(WR_IDX, 32'd0, "R12 write index cleared");
    wr(STATUS, 32'h8);
    expect_reg(STATUS, 32'h0, "R6 halt complete cleared");
    produce(1);
    expect_reg(OUT_FULL, 32'd1, "R12 ring usable after reset");

    finish_run();
  end
endmodule